// File: doc/BRIEF.md
# Link Header Credit Tracker

This block sits on the transmit side of a link layer. It counts how many header buffers are still free at the link partner's receiver. Each header packet it lets through consumes one of those buffers. A transmitter asks to send with `send_req`. The block raises `grant` only while at least one free credit remains. Each accepted send uses one credit and advances a 4-bit header sequence number, which wraps from 15 to 0.

The partner returns credits as link-command words. Credits are lettered, and they must come back in cyclic letter order, starting at letter A (index 0). In normal mode there are `NORM_CREDITS` credits, and the index is taken from command bits [1:0]. In the two-lane high-rate mode there are `WIDE_CREDITS` credits, and the command format changes:

- Bits [2:0] carry the index: 0 to 6 stand for letters A to G, and 7 is reserved.
- Bit 3 names the credit series.

An instance tracks only the series given by its `SERIES` parameter. The mode is latched when `link_reset` is pulsed. The same pulse refills all credits and clears the sequence number.

Any return that is not acceptable raises `credit_err` for one cycle and leaves the credit count unchanged. A return is not acceptable in these cases:

- it is out of order;
- it carries the reserved index;
- it arrives when no credit is outstanding.

Top module: `hdr_credit_tracker`

## Requirements
- R1: After `rst_n` is released, the block is in normal mode with `NORM_CREDITS` free credits, `seq_num` is 0, `grant` is high and `credit_err` is low.
- R2: A cycle with `link_reset` high latches `wide_mode` as the mode, sets the free count to the mode's maximum (`WIDE_CREDITS` if `wide_mode` is 1, otherwise `NORM_CREDITS`), clears `seq_num` and expects letter A next. `wide_mode` has no effect in any other cycle.
- R3: `grant` is high exactly when the free count is non-zero. A `send_req` made while `grant` is low changes nothing.
- R4: A cycle with `send_req` and `grant` both high consumes one credit and increments `seq_num` modulo 16 on the next clock edge.
- R5: A credit return whose index equals the next expected letter adds one credit and advances the expected letter cyclically (after the last letter of the mode comes A). The index is taken from `cmd_word[1:0]` in normal mode and from `cmd_word[2:0]` in wide mode.
- R6: A return whose index differs from the expected letter sets `credit_err` high for the following cycle and does not change the free count.
- R7: In wide mode, index 7 is reserved: it sets `credit_err` and does not change the free count.
- R8: A return made while the free count is already at the mode's maximum is an error (see R6), so the free count never exceeds the maximum.
- R9: In wide mode, a command whose `cmd_word[3]` differs from `SERIES` is ignored: no error and no change to the count. In normal mode, `cmd_word[3:2]` is ignored.
- R10: An accepted send and a valid return in the same cycle leave the free count unchanged, while `seq_num` still increments and the expected letter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | Synchronous link reset; latches mode and refills credits |
| wide_mode | input | 1 | 1 selects the two-lane high-rate credit format at link reset |
| send_req | input | 1 | Request to send one header packet |
| cmd_valid | input | 1 | A credit-return command is present |
| cmd_word | input | 4 | Credit-return command: index and series bit |
| grant | output | 1 | Send permitted this cycle |
| seq_num | output | 4 | Sequence number of the next header packet |
| credit_err | output | 1 | Pulse: the previous command was an illegal return |

## Verification
The bench builds the block with four normal and seven wide credits, and with series 0. This configuration is small enough to sweep, in both modes and for every possible outstanding count from zero to full, every one of the 16 command words. That sweep covers in-order returns, out-of-order returns, the reserved index, over-returns and foreign-series commands. After each sweep step, the bench drains the remaining credits through `grant` to confirm the count. Long runs of sends with simultaneous returns carry the sequence number through several wraps.

// File: rtl/hdr_credit_tracker.sv
module hdr_credit_tracker #(
  parameter int NORM_CREDITS = 4,
  parameter int WIDE_CREDITS = 7,
  parameter int SEQ_W        = 4,
  parameter bit SERIES       = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_reset,
  input  logic             wide_mode,
  input  logic             send_req,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_word,
  output logic             grant,
  output logic [SEQ_W-1:0] seq_num,
  output logic             credit_err
);
  localparam int CW = $clog2(WIDE_CREDITS + 1);

  logic          mode_q;
  logic [CW-1:0] cnt;
  logic [2:0]    rx_ptr;

  wire [CW-1:0] cap      = mode_q ? CW'(WIDE_CREDITS) : CW'(NORM_CREDITS);
  wire [2:0]    idx      = mode_q ? cmd_word[2:0] : {1'b0, cmd_word[1:0]};
  wire          relevant = cmd_valid && !(mode_q && (cmd_word[3] != SERIES));
  wire          reserved = mode_q && (idx == 3'd7);
  wire          good_ret = relevant && !reserved && (idx == rx_ptr) && (cnt != cap);
  wire          bad_ret  = relevant && !good_ret;
  wire          take     = send_req && grant;
  wire [2:0]    ptr_nxt  = (rx_ptr == 3'(cap - CW'(1))) ? 3'd0 : rx_ptr + 3'd1;

  assign grant = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      cnt        <= CW'(NORM_CREDITS);
      rx_ptr     <= '0;
      seq_num    <= '0;
      credit_err <= 1'b0;
    end else if (link_reset) begin
      mode_q     <= wide_mode;
      cnt        <= wide_mode ? CW'(WIDE_CREDITS) : CW'(NORM_CREDITS);
      rx_ptr     <= '0;
      seq_num    <= '0;
      credit_err <= 1'b0;
    end else begin
      cnt        <= cnt + CW'(good_ret) - CW'(take);
      rx_ptr     <= good_ret ? ptr_nxt : rx_ptr;
      seq_num    <= seq_num + SEQ_W'(take);
      credit_err <= bad_ret;
    end
  end
endmodule

// File: rtl/hdr_credit_tracker_chk.sv
module hdr_credit_tracker_chk #(
  parameter int CW    = 3,
  parameter int SEQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_reset,
  input logic             send_req,
  input logic             cmd_valid,
  input logic             wide_mode,
  input logic [3:0]       cmd_word,
  input logic             grant,
  input logic [SEQ_W-1:0] seq_num,
  input logic             credit_err,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    cap
);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap);

  assert_last_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && grant && cnt == CW'(1) && !cmd_valid && !link_reset) |=> !grant);

  assert_link_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |=> (seq_num == '0 && grant && !credit_err));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && grant && !link_reset) |=> seq_num == $past(seq_num) + SEQ_W'(1));

  assert_err_no_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !send_req && !link_reset) |=> (!credit_err || cnt == $past(cnt)));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cap > CW'(4) && cmd_word[2:0] == 3'd7 && !send_req && !link_reset
     && !$past(link_reset && !wide_mode))
    |=> (cnt == $past(cnt)));
endmodule

bind hdr_credit_tracker hdr_credit_tracker_chk #(.CW(CW), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .send_req(send_req),
  .cmd_valid(cmd_valid), .wide_mode(wide_mode), .cmd_word(cmd_word), .grant(grant),
  .seq_num(seq_num), .credit_err(credit_err), .cnt(cnt), .cap(cap)
);

// File: tb/tb_hdr_credit_tracker.sv
`timescale 1ns/1ps
module tb_hdr_credit_tracker;
  localparam int  NC = 4;
  localparam int  WC = 7;
  localparam bit  SER = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_reset = 1'b0, wide_mode = 1'b0, send_req = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd_word = '0;
  logic grant, credit_err;
  logic [3:0] seq_num;

  always #2 clk = ~clk;

  hdr_credit_tracker #(.NORM_CREDITS(NC), .WIDE_CREDITS(WC), .SEQ_W(4), .SERIES(SER)) dut (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .wide_mode(wide_mode),
    .send_req(send_req), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .grant(grant), .seq_num(seq_num), .credit_err(credit_err));

  int checks = 0, errors = 0;
  bit done = 0;
  bit emode = 0;
  int ecnt = NC, eptr = 0, eseq = 0;
  bit eerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic cv, input logic [3:0] w,
                      input logic lr, input logic wd, input string tg);
    int cap, idx;
    bit rel, bad, ok_send;
    @(negedge clk);
    send_req = s; cmd_valid = cv; cmd_word = w; link_reset = lr; wide_mode = wd;
    @(posedge clk);
    if (lr) begin
      emode = wd; ecnt = wd ? WC : NC; eptr = 0; eseq = 0; eerr = 0;
    end else begin
      cap = emode ? WC : NC;
      idx = emode ? int'(w[2:0]) : int'(w[1:0]);
      ok_send = s && ecnt != 0;
      rel = cv && !(emode && w[3] != SER);
      bad = rel && ((emode && idx == 7) || idx != eptr || ecnt == cap);
      if (rel && !bad) begin
        ecnt++;
        eptr = (eptr + 1 == cap) ? 0 : eptr + 1;
      end
      if (ok_send) begin
        ecnt--;
        eseq = (eseq + 1) % 16;
      end
      eerr = bad;
    end
    #1;
    chk(grant === (ecnt != 0), "R3 grant", int'(grant), int'(ecnt != 0));
    chk(seq_num === 4'(eseq), "R4 seq", int'(seq_num), eseq);
    chk(credit_err === eerr, tg, int'(credit_err), int'(eerr));
  endtask

  task automatic drain(input logic wd, input string tg);
    int n = 0;
    int want = ecnt;
    while (grant === 1'b1 && n < 10) begin
      step(1'b1, 1'b0, 4'h0, 1'b0, wd, tg);
      n++;
    end
    chk(n == want, tg, n, want);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(grant === 1'b1, "R1 grant", int'(grant), 1);
    chk(seq_num === 4'd0, "R1 seq", int'(seq_num), 0);
    chk(credit_err === 1'b0, "R1 err", int'(credit_err), 0);
    drain(1'b1, "R1 count");
    step(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, "R3 blocked");

    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k <= (m ? WC : NC); k++) begin
        for (int w = 0; w < 16; w++) begin
          string tg;
          int idx;
          step(1'b0, 1'b0, 4'h0, 1'b1, 1'(m), "R2 reset");
          for (int i = 0; i < k; i++) step(1'b1, 1'b0, 4'h0, 1'b0, 1'(!m), "R2 latch");
          idx = m ? (w & 7) : (w & 3);
          if (m && ((w >> 3) & 1) != int'(SER)) tg = "R9 series";
          else if (m && idx == 7) tg = "R7 reserved";
          else if (k == 0) tg = "R8 over";
          else if (idx == 0) tg = "R5 inorder";
          else tg = "R6 order";
          step(1'b0, 1'b1, 4'(w), 1'b0, 1'(!m), tg);
          drain(1'(!m), tg);
        end
      end
    end

    for (int m = 0; m < 2; m++) begin
      step(1'b0, 1'b0, 4'h0, 1'b1, 1'(m), "R2 reset");
      step(1'b1, 1'b0, 4'h0, 1'b0, 1'(m), "R4 first");
      for (int i = 0; i < 40; i++)
        step(1'b1, 1'b1, 4'(eptr), 1'b0, 1'(m), "R10 overlap");
      chk(ecnt == (m ? WC : NC) - 1, "R10 count", ecnt, (m ? WC : NC) - 1);
      drain(1'(m), "R10 drain");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule